// File: doc/BRIEF.md
# Single/Dual-Slope PWM Timer

This block is a parameterised timer that generates one pulse-width-modulated waveform. The counter runs in one of two ways. In single-slope operation it counts from zero up to the period value and then wraps to zero. In dual-slope operation it climbs from zero to the period value and then descends back to zero, which gives a symmetric, centre-aligned waveform. A compare value sets the duty cycle in both cases. The counter advances on ticks from a prescaler. The prescaler either divides the clock by one of seven fixed ratios or passes through a synchronous event input.

Period and compare writes land in buffer registers. The counter only uses them once it reaches its update point at zero, so a cycle that is in progress is never distorted. Two one-cycle strobes mark the update point and each compare match. The current count is also visible on the ports.

Top module: `pwm_timer`

## Requirements
- R1: During and directly after reset, count_o is 0 and wave_o, update_o and match_o are all low. The active period is 3 and the active compare value is 0.
- R2: psc_sel_i codes 0 to 6 select clock divisors of 1, 2, 4, 8, 64, 256 and 1024. With one of these codes, count_o changes exactly once every N clock cycles.
- R3: psc_sel_i code 7 makes the counter advance once for each clock cycle in which event_i is high. While event_i is low, count_o does not move.
- R4: With mode_i = 0 (single slope), count_o runs 0, 1, … PER and then returns to 0, so each period spans PER+1 counts.
- R5: With mode_i = 1 (dual slope), count_o runs 0, 1, … PER, then PER-1, … 1, then 0 again, so each period spans 2·PER counts.
- R6: In single slope, wave_o is high exactly while count_o < CMP. A CMP of 0 keeps it low, and a CMP of PER+1 or more keeps it high.
- R7: In dual slope, wave_o is high while count_o < CMP on the way up. It drops at the up-count match, rises again at the down-count match, and stays high while count_o ≤ CMP on the way down. A CMP of 0 keeps it low.
- R8: Values written with per_wr_i or cmp_wr_i take effect only at the next update point. The current period and duty finish with the old values.
- R9: update_o pulses for one cycle, in the first cycle that count_o is 0 after a single-slope wrap or a dual-slope return to bottom.
- R10: match_o pulses for one cycle, in the first cycle that count_o holds a value equal to the active compare value.
- R11: A written period below 3 is stored as 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = single slope, 1 = dual slope |
| psc_sel_i | input | 3 | Prescaler select, codes as in R2 and R3 |
| event_i | input | 1 | Event input, counted when psc_sel_i is 7 |
| per_i | input | WIDTH | Period write data |
| per_wr_i | input | 1 | Period buffer write strobe |
| cmp_i | input | WIDTH | Compare write data |
| cmp_wr_i | input | 1 | Compare buffer write strobe |
| count_o | output | WIDTH | Current counter value |
| wave_o | output | 1 | PWM waveform |
| update_o | output | 1 | Update-point strobe |
| match_o | output | 1 | Compare-match strobe |

## Verification
The embedded properties take for granted that event_i is already synchronous to clk. They also rely on a mode change taking effect only at the next tick, and on the active period being at least 3, so that each tick moves the counter to a new value. The bench drives every input at the falling edge and pulses the write strobes for a single cycle. After each write it waits for two update points before it predicts waveforms, so a write that coincides with an update edge cannot skew the expected values. Event pulses are applied only with code 7 selected.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
   localparam int PSC_TAPS    = 7;
   localparam int PSC_SEL_W   = 3;
   localparam int PSC_EVT_SEL = 7;

   typedef enum logic {
      SLOPE_SINGLE = 1'b0,
      SLOPE_DUAL   = 1'b1
   } slope_e;

   // log2 of the divisor for each fixed prescaler code
   function automatic int psc_shift(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         3:       return 3;
         4:       return 6;
         5:       return 8;
         default: return 10;
      endcase
   endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_timer_pkg::*;
#(
   parameter int DIV_BITS = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PSC_SEL_W-1:0] sel_i,
   input  logic                 event_i,
   output logic                 tick_o
);
   localparam int TAP_N = 2 ** PSC_SEL_W;

   if (DIV_BITS < psc_shift(PSC_TAPS - 1)) begin : g_chk_bits
      $error("pwm_prescaler: DIV_BITS too small for largest divisor");
   end
   if (TAP_N != PSC_TAPS + 1) begin : g_chk_taps
      $error("pwm_prescaler: select width does not match tap count");
   end

   logic [DIV_BITS-1:0] div_cnt;
   logic [TAP_N-1:0]    tap;

   always_ff @(posedge clk) begin
      if (!rst_n) div_cnt <= '0;
      else        div_cnt <= div_cnt + 1'b1;
   end

   for (genvar i = 0; i < PSC_TAPS; i++) begin : g_tap
      if (psc_shift(i) == 0) begin : g_pass
         assign tap[i] = 1'b1;
      end else begin : g_and
         assign tap[i] = &div_cnt[psc_shift(i)-1:0];
      end
   end
   assign tap[PSC_EVT_SEL] = event_i;

   assign tick_o = tap[sel_i];

   // R2: divide-by-two ticks never come back to back
   p_div2_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 3'd1 && tick_o) |=> (sel_i != 3'd1 || !tick_o));
   // R3: in event mode a tick appears only with the event input
   p_event_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == 3'(PSC_EVT_SEL) && !event_i) |-> !tick_o);
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
   parameter int WIDTH   = 16,
   parameter int MIN_PER = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] per_i,
   input  logic             per_wr_i,
   input  logic [WIDTH-1:0] cmp_i,
   input  logic             cmp_wr_i,
   input  logic             load_i,
   output logic [WIDTH-1:0] per_act_o,
   output logic [WIDTH-1:0] cmp_act_o
);
   localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN_PER);

   logic [WIDTH-1:0] per_buf, cmp_buf, per_in;

   assign per_in = (per_i < MIN_V) ? MIN_V : per_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_buf   <= MIN_V;
         cmp_buf   <= '0;
         per_act_o <= MIN_V;
         cmp_act_o <= '0;
      end else begin
         if (per_wr_i) per_buf <= per_in;
         if (cmp_wr_i) cmp_buf <= cmp_i;
         if (load_i) begin
            per_act_o <= per_buf;
            cmp_act_o <= cmp_buf;
         end
      end
   end

   // R11: the active period never drops below the floor
   p_per_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
      per_act_o >= MIN_V);
   // R8: active values move only at an update point
   p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(per_act_o) && $stable(cmp_act_o)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             dual_i,
   input  logic [WIDTH-1:0] per_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             up_o,
   output logic             wrap_o,
   output logic             step_o
);
   logic [WIDTH-1:0] cnt_n;
   logic             up_n;

   always_comb begin
      cnt_n  = cnt_o;
      up_n   = up_o;
      wrap_o = 1'b0;
      if (tick_i) begin
         if (!dual_i) begin
            up_n = 1'b1;
            if (cnt_o >= per_i) begin
               cnt_n  = '0;
               wrap_o = 1'b1;
            end else begin
               cnt_n = cnt_o + 1'b1;
            end
         end else if (up_o) begin
            if (cnt_o >= per_i) begin
               up_n  = 1'b0;
               cnt_n = cnt_o - 1'b1;
            end else begin
               cnt_n = cnt_o + 1'b1;
            end
         end else begin
            if (cnt_o <= WIDTH'(1)) begin
               cnt_n  = '0;
               up_n   = 1'b1;
               wrap_o = 1'b1;
            end else begin
               cnt_n = cnt_o - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         up_o   <= 1'b1;
         step_o <= 1'b0;
      end else begin
         cnt_o  <= cnt_n;
         up_o   <= up_n;
         step_o <= tick_i;
      end
   end

   // R2: without a tick the count holds
   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));
   // R4: single slope wraps to zero at the period
   p_single_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !dual_i && cnt_o == per_i) |=> cnt_o == '0);
   // R5: dual slope turns around at the top
   p_dual_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && dual_i && up_o && cnt_o == per_i) |=> (!up_o && cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cnt_i,
   input  logic             up_i,
   input  logic             dual_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] cmp_i,
   output logic             wave_o,
   output logic             match_o,
   output logic             update_o
);
   always_comb begin
      if (cmp_i == '0)          wave_o = 1'b0;
      else if (dual_i && !up_i) wave_o = (cnt_i <= cmp_i);
      else                      wave_o = (cnt_i < cmp_i);
   end

   assign match_o  = step_i && (cnt_i == cmp_i);
   assign update_o = step_i && (cnt_i == '0);

   // R6, R7: a zero compare value keeps the waveform low
   p_cmp0_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_i == '0) |-> !wave_o);
   // R9: the update strobe lasts a single cycle
   p_update_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      update_o |=> !update_o);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwm_timer_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int DIV_BITS = 10,
   parameter int MIN_PER  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_i,
   input  logic [PSC_SEL_W-1:0] psc_sel_i,
   input  logic                 event_i,
   input  logic [WIDTH-1:0]     per_i,
   input  logic                 per_wr_i,
   input  logic [WIDTH-1:0]     cmp_i,
   input  logic                 cmp_wr_i,
   output logic [WIDTH-1:0]     count_o,
   output logic                 wave_o,
   output logic                 update_o,
   output logic                 match_o
);
   if (WIDTH < 2) begin : g_chk_width
      $error("pwm_timer: WIDTH must be at least 2");
   end
   if (MIN_PER < 3 || MIN_PER >= 2 ** WIDTH) begin : g_chk_min
      $error("pwm_timer: MIN_PER out of range");
   end

   logic             tick, wrap, step, up, dual;
   logic [WIDTH-1:0] per_act, cmp_act;

   assign dual = (slope_e'(mode_i) == SLOPE_DUAL);

   pwm_prescaler #(.DIV_BITS(DIV_BITS)) u_psc (
      .clk(clk), .rst_n(rst_n), .sel_i(psc_sel_i), .event_i(event_i), .tick_o(tick));

   pwm_shadow #(.WIDTH(WIDTH), .MIN_PER(MIN_PER)) u_shadow (
      .clk(clk), .rst_n(rst_n), .per_i(per_i), .per_wr_i(per_wr_i),
      .cmp_i(cmp_i), .cmp_wr_i(cmp_wr_i), .load_i(wrap),
      .per_act_o(per_act), .cmp_act_o(cmp_act));

   pwm_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .dual_i(dual), .per_i(per_act),
      .cnt_o(count_o), .up_o(up), .wrap_o(wrap), .step_o(step));

   pwm_wavegen #(.WIDTH(WIDTH)) u_wave (
      .clk(clk), .rst_n(rst_n), .cnt_i(count_o), .up_i(up), .dual_i(dual),
      .step_i(step), .cmp_i(cmp_act), .wave_o(wave_o), .match_o(match_o),
      .update_o(update_o));

   // R4, R5: the count stays within the active period
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= per_act);
   // R6: a compare value beyond the period keeps the waveform high
   p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act > per_act) |-> wave_o);
   // R10: a match strobe reports the active compare value
   p_match_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (count_o == cmp_act));
endmodule

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_i = 1'b0;
   logic [2:0]  psc_sel_i = 3'd0;
   logic        event_i = 1'b0;
   logic [15:0] per_i = '0;
   logic        per_wr_i = 1'b0;
   logic [15:0] cmp_i = '0;
   logic        cmp_wr_i = 1'b0;
   logic [15:0] count_o;
   logic        wave_o, update_o, match_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   pwm_timer u_pwm_timer (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .psc_sel_i(psc_sel_i),
      .event_i(event_i), .per_i(per_i), .per_wr_i(per_wr_i), .cmp_i(cmp_i),
      .cmp_wr_i(cmp_wr_i), .count_o(count_o), .wave_o(wave_o),
      .update_o(update_o), .match_o(match_o));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0d exp=%0d at count=%0d", req, act, exp, count_o);
      end
   endtask

   task automatic write_regs(input int per, input int cmp, input bit wp, input bit wc);
      per_i = 16'(per); cmp_i = 16'(cmp);
      per_wr_i = wp; cmp_wr_i = wc;
      @(negedge clk);
      per_wr_i = 1'b0; cmp_wr_i = 1'b0;
   endtask

   task automatic wait_update(input string req);
      int n = 0;
      @(negedge clk);
      while (!update_o && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(req, int'(update_o), 1);
   endtask

   task automatic sync2(input string req);
      wait_update(req);
      wait_update(req);
   endtask

   task automatic t_reset;
      check("R1 count", int'(count_o), 0);
      check("R1 wave", int'(wave_o), 0);
      check("R1 update", int'(update_o), 0);
      check("R1 match", int'(match_o), 0);
   endtask

   // single slope: period 9, compare 4, with a buffered rewrite mid-period
   task automatic t_single_walk;
      write_regs(9, 4, 1, 1);
      sync2("R9");
      for (int k = 0; k <= 9; k++) begin
         if (k > 0) @(negedge clk);
         check("R4 count", int'(count_o), k);
         check("R6 wave", int'(wave_o), int'(k < 4));
         check("R10 match", int'(match_o), int'(k == 4));
         check("R9 update", int'(update_o), int'(k == 0));
         if (k == 2) begin
            per_i = 16'd5; cmp_i = 16'd1; per_wr_i = 1'b1; cmp_wr_i = 1'b1;
         end else begin
            per_wr_i = 1'b0; cmp_wr_i = 1'b0;
         end
      end
      @(negedge clk);
      check("R8 wrap after old period", int'(count_o), 0);
      check("R9 update at wrap", int'(update_o), 1);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         check("R8 new period count", int'(count_o), k);
         check("R8 new duty wave", int'(wave_o), 0);
      end
      @(negedge clk);
      check("R8 new period wraps", int'(count_o), 0);
   endtask

   task automatic t_single_edges;
      write_regs(0, 0, 0, 1);
      sync2("R6");
      for (int k = 0; k < 12; k++) begin
         check("R6 cmp0 low", int'(wave_o), 0);
         @(negedge clk);
      end
      write_regs(0, 6, 0, 1);
      sync2("R6");
      for (int k = 0; k < 12; k++) begin
         check("R6 cmp beyond period high", int'(wave_o), 1);
         @(negedge clk);
      end
   endtask

   task automatic t_clamp;
      write_regs(1, 2, 1, 1);
      sync2("R11");
      for (int k = 0; k <= 3; k++) begin
         if (k > 0) @(negedge clk);
         check("R11 clamped count", int'(count_o), k);
         check("R11 wave", int'(wave_o), int'(k < 2));
      end
      @(negedge clk);
      check("R11 wraps after 3", int'(count_o), 0);
   endtask

   task automatic t_dual_walk;
      mode_i = 1'b1;
      write_regs(6, 2, 1, 1);
      sync2("R9");
      for (int j = 0; j < 12; j++) begin
         int v = (j <= 6) ? j : 12 - j;
         bit up = (j <= 6);
         if (j > 0) @(negedge clk);
         check("R5 count", int'(count_o), v);
         check("R7 wave", int'(wave_o), up ? int'(v < 2) : int'(v <= 2));
         check("R10 match", int'(match_o), int'(v == 2));
         check("R9 update", int'(update_o), int'(j == 0));
      end
      @(negedge clk);
      check("R5 bottom", int'(count_o), 0);
      check("R9 update at bottom", int'(update_o), 1);
   endtask

   task automatic t_dual_edges;
      write_regs(0, 0, 0, 1);
      sync2("R7");
      for (int k = 0; k < 14; k++) begin
         check("R7 cmp0 low", int'(wave_o), 0);
         @(negedge clk);
      end
      write_regs(0, 9, 0, 1);
      sync2("R7");
      for (int k = 0; k < 14; k++) begin
         check("R7 cmp beyond period high", int'(wave_o), 1);
         @(negedge clk);
      end
   endtask

   task automatic t_prescale;
      int divs[7] = '{1, 2, 4, 8, 64, 256, 1024};
      mode_i = 1'b0;
      for (int s = 0; s < 7; s++) begin
         int n = 0;
         logic [15:0] prev;
         psc_sel_i = 3'(s);
         @(negedge clk);
         prev = count_o;
         while (count_o == prev && n < 3000) begin
            @(negedge clk);
            n++;
         end
         prev = count_o;
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (count_o == prev && n < 3000);
         check("R2 divisor", n, divs[s]);
      end
   endtask

   task automatic t_event;
      int c0;
      psc_sel_i = 3'd7;
      event_i = 1'b0;
      @(negedge clk);
      c0 = int'(count_o);
      repeat (20) @(negedge clk);
      check("R3 no event no advance", int'(count_o), c0);
      event_i = 1'b1;
      repeat (3) @(negedge clk);
      event_i = 1'b0;
      check("R3 three events", int'(count_o), (c0 + 3) % 7);
      repeat (5) @(negedge clk);
      check("R3 hold after events", int'(count_o), (c0 + 3) % 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_single_walk;
      t_single_edges;
      t_clamp;
      t_dual_walk;
      t_dual_edges;
      t_prescale;
      t_event;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule